// File: doc/BRIEF.md
# Four-Phase Instruction Fetch Sequencer

This block sets the instruction-cycle rhythm and program-counter behaviour of a small core with 12-bit instruction words. Each instruction cycle lasts four clocks, named Q1, Q2, Q3 and Q4. Fetch and execute overlap. While one word executes from the instruction register, the next word is read from program memory at the current address. At the clock edge that closes Q4, the fetched word moves into the instruction register and the program counter advances.

A taken branch is reported on `br_taken` together with a target field and page-select bits. It loads the counter with the page bits placed above the target field. It also replaces the prefetched word with a no-operation, so a branch costs two cycles.

All addresses are masked to the implemented depth, which is a parameter. Addresses therefore wrap inside a smaller region of the 12-bit space. The core strobes its data memory through `opnd_rd` (read in Q2) and `dest_wr` (write in Q4). A flushed slot strobes neither.

The phase generator is a four-state machine with states PH_Q1, PH_Q2, PH_Q3 and PH_Q4, and four transitions:

| Transition | From | To |
|---|---|---|
| ADV_Q1_Q2 | PH_Q1 | PH_Q2 |
| ADV_Q2_Q3 | PH_Q2 | PH_Q3 |
| ADV_Q3_Q4 | PH_Q3 | PH_Q4 |
| WRAP_Q4_Q1 | PH_Q4 | PH_Q1 |

WRAP_Q4_Q1 is the cycle boundary, where fetch and branch decisions take effect. Reset forces PH_Q1.

Top module: `fetch_seq`

## Requirements
- R1: `phase_q` is one-hot. Bit 0 is Q1, bit 1 Q2, bit 2 Q3 and bit 3 Q4. It steps Q1, Q2, Q3, Q4, then back to Q1, one step per clock, and is Q1 during reset.
- R2: During reset and in the first cycle after it, `prog_addr` is 000h and `instr_reg` is the no-operation word 000h. Neither strobe is asserted in that first cycle.
- R3: At the edge that ends Q4, `instr_reg` takes the `prog_data` word present at that edge and `prog_addr` becomes the old address plus one. `prog_addr` does not change within a cycle.
- R4: `opnd_rd` is high only in Q2 and `dest_wr` only in Q4, in every cycle whose slot holds a fetched word.
- R5: `br_taken` high at the edge ending Q4 of a non-flushed cycle makes the next `prog_addr` equal {`page_sel`, `br_target`} masked to the depth, and loads `instr_reg` with 000h. The following cycle is a flushed slot with no strobes; the word at the target executes in the cycle after it.
- R6: `br_taken` is ignored during a flushed slot and whenever it is low at the edge ending Q4. The address then advances by one.
- R7: With DEPTH = 1024, the address after 3FFh is 000h, and branch targets keep only bits 9:0 (page bit 1 is dropped).
- R8: Every instruction cycle, including a flushed one, lasts exactly four clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_data | input | 12 | Program memory word read at `prog_addr` |
| br_taken | input | 1 | Branch taken by the executing instruction |
| br_target | input | 9 | Target field of the branch |
| page_sel | input | 2 | Page bits placed above the target field |
| prog_addr | output | 12 | Program memory address (program counter) |
| instr_reg | output | 12 | Instruction being executed |
| phase_q | output | 4 | One-hot phase indicator, bit 0 = Q1 |
| opnd_rd | output | 1 | Operand read strobe (Q2) |
| dest_wr | output | 1 | Destination write strobe (Q4) |

## Verification
A phase state out of order appears at once on `phase_q`. It shifts the strobes and breaks the four-clock cadence at the next Q1. A wrong counter value, either a missed increment or a missing mask, appears on `prog_addr` in the very next cycle. It then feeds a wrong word into `instr_reg` one cycle later. A lost flush marker shows within the same cycle: strobes fire in a slot that should be silent, and a branch held high during the flush is followed when it should be ignored.

// File: rtl/fi_pkg.sv
package fi_pkg;
    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

    localparam int WORD_W = 12;
    localparam logic [WORD_W-1:0] NOP_WORD = '0;
endpackage

// File: rtl/fi_phase_gen.sv
module fi_phase_gen
    import fi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    output logic [3:0] phase_oh,
    output logic       cyc_end
);
    phase_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= PH_Q1;
        else        state <= state_nx;
    end

    // transitions ADV_Q1_Q2, ADV_Q2_Q3, ADV_Q3_Q4, WRAP_Q4_Q1
    always_comb begin
        unique case (state)
            PH_Q1: state_nx = PH_Q2;
            PH_Q2: state_nx = PH_Q3;
            PH_Q3: state_nx = PH_Q4;
            PH_Q4: state_nx = PH_Q1;
            default: state_nx = PH_Q1;
        endcase
    end

    always_comb begin
        unique case (state)
            PH_Q1: begin phase_oh = 4'b0001; cyc_end = 1'b0; end
            PH_Q2: begin phase_oh = 4'b0010; cyc_end = 1'b0; end
            PH_Q3: begin phase_oh = 4'b0100; cyc_end = 1'b0; end
            PH_Q4: begin phase_oh = 4'b1000; cyc_end = 1'b1; end
            default: begin phase_oh = 4'b0001; cyc_end = 1'b0; end
        endcase
    end

    assert_phase_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(phase_oh));
endmodule

// File: rtl/fi_pc_unit.sv
module fi_pc_unit #(
    parameter int PC_W   = 12,
    parameter int DEPTH  = 1024,
    parameter int TGT_W  = 9,
    parameter int PAGE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_end,
    input  logic              take_br,
    input  logic [TGT_W-1:0]  br_target,
    input  logic [PAGE_W-1:0] page_sel,
    output logic [PC_W-1:0]   pc
);
    localparam int JW = PAGE_W + TGT_W;
    localparam logic [PC_W-1:0] ADDR_MASK = PC_W'(DEPTH - 1);

    logic [PC_W-1:0] jump_full;
    logic [PC_W-1:0] pc_inc;

    generate
        if (JW < PC_W) begin : g_pad
            assign jump_full = {{(PC_W-JW){1'b0}}, page_sel, br_target};
        end else begin : g_trim
            logic [JW-1:0] jw_raw;
            assign jw_raw    = {page_sel, br_target};
            assign jump_full = jw_raw[PC_W-1:0];
        end
    endgenerate

    assign pc_inc = (pc + PC_W'(1)) & ADDR_MASK;

    always_ff @(posedge clk) begin
        if (!rst_n)       pc <= '0;
        else if (cyc_end) pc <= take_br ? (jump_full & ADDR_MASK) : pc_inc;
    end

    assert_addr_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pc <= ADDR_MASK);
    assert_branch_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end && take_br) |=>
            (pc == (PC_W'({$past(page_sel), $past(br_target)}) & ADDR_MASK)));
    assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end && !take_br) |=> (pc == (($past(pc) + PC_W'(1)) & ADDR_MASK)));
endmodule

// File: rtl/fi_ir_stage.sv
module fi_ir_stage
    import fi_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cyc_end,
    input  logic         take_br,
    input  logic [W-1:0] fetch_word,
    output logic [W-1:0] ir,
    output logic         slot_valid
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir         <= W'(NOP_WORD);
            slot_valid <= 1'b0;
        end else if (cyc_end) begin
            if (take_br) begin
                ir         <= W'(NOP_WORD);
                slot_valid <= 1'b0;
            end else begin
                ir         <= fetch_word;
                slot_valid <= 1'b1;
            end
        end
    end

    assert_flush_nop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end && take_br) |=> (ir == W'(NOP_WORD) && !slot_valid));
    assert_flush_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end && !slot_valid) |=> slot_valid);
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq #(
    parameter int PC_W   = 12,
    parameter int DEPTH  = 1024,
    parameter int TGT_W  = 9,
    parameter int PAGE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       prog_data,
    input  logic              br_taken,
    input  logic [TGT_W-1:0]  br_target,
    input  logic [PAGE_W-1:0] page_sel,
    output logic [PC_W-1:0]   prog_addr,
    output logic [11:0]       instr_reg,
    output logic [3:0]        phase_q,
    output logic              opnd_rd,
    output logic              dest_wr
);
    logic cyc_end;
    logic slot_valid;
    logic take_br;

    fi_phase_gen u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_oh (phase_q),
        .cyc_end  (cyc_end)
    );

    assign take_br = cyc_end & slot_valid & br_taken;

    fi_pc_unit #(.PC_W(PC_W), .DEPTH(DEPTH), .TGT_W(TGT_W), .PAGE_W(PAGE_W)) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_end   (cyc_end),
        .take_br   (take_br),
        .br_target (br_target),
        .page_sel  (page_sel),
        .pc        (prog_addr)
    );

    fi_ir_stage #(.W(12)) u_ir (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_end    (cyc_end),
        .take_br    (take_br),
        .fetch_word (prog_data),
        .ir         (instr_reg),
        .slot_valid (slot_valid)
    );

    assign opnd_rd = phase_q[1] & slot_valid;
    assign dest_wr = phase_q[3] & slot_valid;

    assert_phase_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q[0] |=> phase_q[1]);
    assert_phase_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q[3] |=> phase_q[0]);
    assert_rd_in_q2_R4: assert property (@(posedge clk) disable iff (!rst_n)
        opnd_rd |-> phase_q[1]);
    assert_wr_in_q4_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dest_wr |-> phase_q[3]);
    assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_q[0] |-> $stable(prog_addr));
endmodule

// File: tb/sim_fetch_seq.sv
module sim_fetch_seq;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] MASK = 12'h3FF;

    typedef struct {
        logic [11:0] addr;
        logic [11:0] ir;
        logic        valid;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] prog_data;
    logic        br_taken = 1'b0;
    logic [8:0]  br_target = '0;
    logic [1:0]  page_sel = '0;
    logic [11:0] prog_addr;
    logic [11:0] instr_reg;
    logic [3:0]  phase_q;
    logic        opnd_rd;
    logic        dest_wr;

    int n_cmp = 0;
    int n_bad = 0;
    item_t exp_q[$];
    item_t cur;
    bit    have_cur = 0;
    int    since_q1 = -1;
    bit    done = 0;

    logic [11:0] m_pc = '0;
    logic [11:0] m_ir = '0;
    logic        m_valid = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [11:0] memf(input logic [11:0] a);
        return a * 12'd7 + 12'h123;
    endfunction

    assign prog_data = memf(prog_addr);

    fetch_seq u0 (
        .clk(clk), .rst_n(rst_n), .prog_data(prog_data),
        .br_taken(br_taken), .br_target(br_target), .page_sel(page_sel),
        .prog_addr(prog_addr), .instr_reg(instr_reg), .phase_q(phase_q),
        .opnd_rd(opnd_rd), .dest_wr(dest_wr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // driver: pushes the expected slot, drives branch inputs for one cycle
    task automatic do_cycle(input bit bt, input logic [8:0] tgt,
                            input logic [1:0] pg, input bit early_only);
        item_t it;
        it.addr = m_pc; it.ir = m_ir; it.valid = m_valid;
        exp_q.push_back(it);
        br_target = tgt; page_sel = pg; br_taken = bt;
        if (early_only) begin
            repeat (2) @(negedge clk);
            br_taken = 1'b0;
            repeat (2) @(negedge clk);
        end else begin
            repeat (4) @(negedge clk);
        end
        br_taken = 1'b0;
        if (m_valid && bt && !early_only) begin
            m_pc = {1'b0, pg, tgt} & MASK;
            m_ir = 12'h000;
            m_valid = 1'b0;
        end else begin
            m_ir = memf(m_pc);
            m_pc = (m_pc + 12'd1) & MASK;
            m_valid = 1'b1;
        end
    endtask

    // monitor
    always @(negedge clk) begin
        #1;
        if (!rst_n) begin
            chk(prog_addr == 12'h000, "R2", "reset addr", prog_addr, 0);
            chk(instr_reg == 12'h000, "R2", "reset ir", instr_reg, 0);
            chk(phase_q == 4'b0001, "R1", "reset phase", phase_q, 1);
            chk(!opnd_rd && !dest_wr, "R2", "reset strobes", {opnd_rd, dest_wr}, 0);
        end else if (!done) begin
            if (phase_q == 4'b0001) begin
                if (since_q1 >= 0)
                    chk(since_q1 == 4, "R8", "cycle length", since_q1, 4);
                since_q1 = 0;
                if (exp_q.size() > 0) begin
                    cur = exp_q.pop_front();
                    have_cur = 1;
                    chk(prog_addr == cur.addr, "R3/R5/R7", "prog_addr", prog_addr, cur.addr);
                    chk(instr_reg == cur.ir, "R3/R5", "instr_reg", instr_reg, cur.ir);
                    chk(!opnd_rd && !dest_wr, "R4", "Q1 strobes", {opnd_rd, dest_wr}, 0);
                end
            end else if (have_cur) begin
                chk(prog_addr == cur.addr, "R3", "addr stable", prog_addr, cur.addr);
                if (phase_q == 4'b0010)
                    chk(opnd_rd == cur.valid && !dest_wr, "R4", "Q2 strobes",
                        {opnd_rd, dest_wr}, {cur.valid, 1'b0});
                else if (phase_q == 4'b0100)
                    chk(!opnd_rd && !dest_wr, "R4", "Q3 strobes", {opnd_rd, dest_wr}, 0);
                else if (phase_q == 4'b1000)
                    chk(dest_wr == cur.valid && !opnd_rd, "R4", "Q4 strobes",
                        {opnd_rd, dest_wr}, {1'b0, cur.valid});
                else
                    chk(1'b0, "R1", "phase onehot", phase_q, 0);
            end
            if (since_q1 >= 0) since_q1++;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: first cycle after reset is a silent slot
        for (int i = 0; i < 8; i++) do_cycle(1'b0, 9'h000, 2'b00, 1'b0);
        // R5: branch into page 1 -> 3F0h
        do_cycle(1'b1, 9'h1F0, 2'b01, 1'b0);
        // R6: branch held during flushed slot is ignored
        do_cycle(1'b1, 9'h033, 2'b00, 1'b0);
        // R7: walk across 3FFh -> 000h
        for (int i = 0; i < 18; i++) do_cycle(1'b0, 9'h000, 2'b00, 1'b0);
        // R6: branch pulse that drops before Q4 is ignored
        do_cycle(1'b1, 9'h0AA, 2'b00, 1'b1);
        do_cycle(1'b0, 9'h000, 2'b00, 1'b0);
        // R7: page bit 1 masked: {11,005h} -> 205h
        do_cycle(1'b1, 9'h005, 2'b11, 1'b0);
        do_cycle(1'b0, 9'h000, 2'b00, 1'b0);
        do_cycle(1'b0, 9'h000, 2'b00, 1'b0);
        // R5: back-to-back branches from valid slots
        do_cycle(1'b1, 9'h100, 2'b00, 1'b0);
        do_cycle(1'b0, 9'h000, 2'b00, 1'b0);
        do_cycle(1'b1, 9'h010, 2'b00, 1'b0);
        for (int i = 0; i < 4; i++) do_cycle(1'b0, 9'h000, 2'b00, 1'b0);
        done = 1;
        chk(exp_q.size() == 0, "R8", "queue drained", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule